// File: doc/BRIEF.md
# Masked-Write Memory Port Controller

This block is a clock-synchronous model of the random-access side of a 4-bit-wide multiport memory. Four active-low strobes drive it: a row strobe, a column strobe, a write enable and an output enable. Every strobe is sampled on the system clock. A strobe edge is a change between two successive samples. A single 4-bit bus is split into an input, an output and an output-enable signal. The bus first supplies a per-bit write mask, taken when the row strobe asserts. Later in the same row cycle it carries write data or read data.

A write stores only the bits whose mask bit is 1. The mask lasts for one row cycle. The data word is captured on the clock where the column strobe and the write enable are first both low, whichever of the two fell last. Read data drives the bus only while the row is open, both the column strobe and the output enable are low, and the cycle is a read. The output turns off as soon as either of those two strobes rises.

The strobes set the timing of the bus, so there is no valid/ready handshake and no back-pressure. A host must hold each strobe level for at least one clock so that its edges are seen.

Top module: `mwport_ctrl`

## Requirements
- R1: After reset, `bus_oe` is 0 and every array word reads 0.
- R2: The row address and the 4-bit mask on `bus_in` are captured on the clock where `row_stb_n` is first seen low. Values on `bus_in` later in the row cycle do not change the mask.
- R3: A write sets stored bit i to the data bit where mask bit i is 1. Bits whose mask bit is 0 keep their previous value.
- R4: A write with an all-zero mask leaves the addressed word unchanged.
- R5: When `col_stb_n` falls before `wr_en_n`, the data on `bus_in` is captured on the clock where `wr_en_n` is first seen low.
- R6: When `wr_en_n` falls before `col_stb_n`, the data is captured on the clock where `col_stb_n` is first seen low. That clock also latches the column address.
- R7: `bus_oe` is 1 only when a row is open, the column strobe has been seen falling, both `col_stb_n` and `out_en_n` are low, and `wr_en_n` is high. While it is 1, `bus_out` shows the word at {row, column}.
- R8: When `col_stb_n` rises while `out_en_n` is still low, `bus_oe` drops in the same cycle.
- R9: When `out_en_n` rises while `col_stb_n` is still low, `bus_oe` drops in the same cycle.
- R10: The mask is discarded when `row_stb_n` rises. Column and write strobes given with no row open write nothing.
- R11: If `wr_en_n` stays high while the column strobe is low, the cycle is a read and the array is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_stb_n | input | 1 | Row strobe, active low |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_en_n | input | 1 | Write enable, active low |
| out_en_n | input | 1 | Output enable, active low |
| row_addr | input | ROW_W | Row address |
| col_addr | input | COL_W | Column address |
| bus_in | input | DATA_W | Bus input: mask at row start, then data |
| bus_out | output | DATA_W | Read data |
| bus_oe | output | 1 | High when `bus_out` drives the bus |

## Verification
The bench runs both orderings of the column-strobe and write-enable edges. A design that uses only one strobe's edge as the trigger would capture stale bus contents, or the mask itself, as data. It writes with partial masks and with an all-zero mask. A design that ignores the mask, or applies it inverted, corrupts neighbouring bits. It releases the output with the column strobe first and then with the output enable first, so a release gated on one strobe alone leaves the bus driven. Last, it gives column and write strobes after the row closes. A mask that outlives its row would then produce a write.

// File: rtl/mwp_pkg.sv
package mwp_pkg;
  localparam int NUM_SYNC = 3;
  localparam int SI_ROW = 0;
  localparam int SI_COL = 1;
  localparam int SI_WE  = 2;

  function automatic logic [3:0] merge4(input logic [3:0] old_w,
                                        input logic [3:0] new_w,
                                        input logic [3:0] keep_new);
    return (old_w & ~keep_new) | (new_w & keep_new);
  endfunction
endpackage

// File: rtl/mwp_strobe_sync.sv
module mwp_strobe_sync #(
  parameter int NS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] stb_n,
  output logic [NS-1:0] stb_prev_n
);
  for (genvar g = 0; g < NS; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_prev_n[g] <= 1'b1;
      else        stb_prev_n[g] <= stb_n[g];
    end
  end
endmodule

// File: rtl/mwp_cycle_ctl.sv
module mwp_cycle_ctl #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4,
  parameter int NS     = mwp_pkg::NUM_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NS-1:0]     stb_n,
  input  logic [NS-1:0]     stb_prev_n,
  input  logic              out_en_n,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ROW_W-1:0]  row_q,
  output logic [COL_W-1:0]  col_q,
  output logic [COL_W-1:0]  wr_col,
  output logic [DATA_W-1:0] mask_q,
  output logic              wr_fire,
  output logic              drive_en
);
  import mwp_pkg::*;

  logic row_act, col_act, wr_cyc;
  logic row_fall, row_rise, col_fall, col_rise;
  logic pair_now, pair_prev;

  always_comb begin
    row_fall  = stb_prev_n[SI_ROW] & ~stb_n[SI_ROW];
    row_rise  = ~stb_prev_n[SI_ROW] & stb_n[SI_ROW];
    col_fall  = stb_prev_n[SI_COL] & ~stb_n[SI_COL];
    col_rise  = ~stb_prev_n[SI_COL] & stb_n[SI_COL];
    pair_now  = ~stb_n[SI_COL] & ~stb_n[SI_WE];
    pair_prev = ~stb_prev_n[SI_COL] & ~stb_prev_n[SI_WE];
    wr_fire   = row_act & ~stb_n[SI_ROW] & pair_now & ~pair_prev;
    wr_col    = col_fall ? col_addr : col_q;
    drive_en  = row_act & col_act & ~stb_n[SI_COL] & ~out_en_n
              & stb_n[SI_WE] & ~wr_cyc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q   <= '0;
      col_q   <= '0;
      mask_q  <= '0;
      row_act <= 1'b0;
      col_act <= 1'b0;
      wr_cyc  <= 1'b0;
    end else begin
      if (row_fall) begin
        row_q   <= row_addr;
        mask_q  <= bus_in;
        row_act <= 1'b1;
      end else if (row_rise) begin
        mask_q  <= '0;
        row_act <= 1'b0;
      end
      if (col_fall) begin
        col_q   <= col_addr;
        col_act <= 1'b1;
      end else if (col_rise) begin
        col_act <= 1'b0;
      end
      if (col_rise || row_rise) wr_cyc <= 1'b0;
      else if (wr_fire)         wr_cyc <= 1'b1;
    end
  end
endmodule

// File: rtl/mwp_store.sv
module mwp_store #(
  parameter int AW = 6,
  parameter int DW = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [AW-1:0]         wr_addr,
  input  logic [DW-1:0]         wr_mask,
  input  logic [DW-1:0]         wr_data,
  input  logic [AW-1:0]         rd_addr,
  output logic [DW-1:0]         rd_data,
  output logic [(1<<AW)*DW-1:0] mem_flat
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  for (genvar w = 0; w < DEPTH; w++) begin : g_word
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[w] <= '0;
      else if (wr_en && wr_addr == AW'(w))
        mem[w] <= (mem[w] & ~wr_mask) | (wr_data & wr_mask);
    end
    assign mem_flat[w*DW +: DW] = mem[w];
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/mwport_ctrl.sv
module mwport_ctrl #(
  parameter int ROW_W  = 3,
  parameter int COL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_stb_n,
  input  logic              col_stb_n,
  input  logic              wr_en_n,
  input  logic              out_en_n,
  input  logic [ROW_W-1:0]  row_addr,
  input  logic [COL_W-1:0]  col_addr,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  import mwp_pkg::*;
  localparam int AW    = ROW_W + COL_W;
  localparam int FLATW = (1 << AW) * DATA_W;

  logic [NUM_SYNC-1:0] stb_n, stb_prev_n;
  logic [ROW_W-1:0]    row_q;
  logic [COL_W-1:0]    col_q, wr_col;
  logic [DATA_W-1:0]   mask_q;
  logic                wr_fire;
  logic [FLATW-1:0]    mem_flat;

  always_comb begin
    stb_n         = '1;
    stb_n[SI_ROW] = row_stb_n;
    stb_n[SI_COL] = col_stb_n;
    stb_n[SI_WE]  = wr_en_n;
  end

  mwp_strobe_sync #(.NS(NUM_SYNC)) u_sync (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .stb_prev_n(stb_prev_n)
  );

  mwp_cycle_ctl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .NS(NUM_SYNC)) u_ctl (
    .clk(clk), .rst_n(rst_n), .stb_n(stb_n), .stb_prev_n(stb_prev_n),
    .out_en_n(out_en_n), .row_addr(row_addr), .col_addr(col_addr),
    .bus_in(bus_in), .row_q(row_q), .col_q(col_q), .wr_col(wr_col),
    .mask_q(mask_q), .wr_fire(wr_fire), .drive_en(bus_oe)
  );

  mwp_store #(.AW(AW), .DW(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_fire),
    .wr_addr({row_q, wr_col}), .wr_mask(mask_q), .wr_data(bus_in),
    .rd_addr({row_q, col_q}), .rd_data(bus_out), .mem_flat(mem_flat)
  );
endmodule

// File: rtl/mwport_ctrl_chk.sv
module mwport_ctrl_chk #(
  parameter int DATA_W = 4,
  parameter int FLATW  = 256
) (
  input logic              clk,
  input logic              rst_n,
  input logic              row_stb_n,
  input logic              col_stb_n,
  input logic              wr_en_n,
  input logic              out_en_n,
  input logic              bus_oe,
  input logic [DATA_W-1:0] mask_q,
  input logic [FLATW-1:0]  mem_flat
);
  AST_COL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(col_stb_n) |-> !bus_oe); // R8
  AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_en_n) |-> !bus_oe); // R9
  AST_ZERO_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |=> $stable(mem_flat)); // R4
  AST_NO_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    row_stb_n |=> $stable(mem_flat)); // R10
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_n |=> $stable(mem_flat)); // R11
endmodule

bind mwport_ctrl mwport_ctrl_chk #(.DATA_W(DATA_W), .FLATW(FLATW)) u_chk (
  .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
  .wr_en_n(wr_en_n), .out_en_n(out_en_n), .bus_oe(bus_oe),
  .mask_q(mask_q), .mem_flat(mem_flat)
);

// File: tb/mwport_ctrl_bench.sv
module mwport_ctrl_bench;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_en_n = 1'b1, out_en_n = 1'b1;
  logic [2:0] row_addr = '0, col_addr = '0;
  logic [3:0] bus_in = '0;
  logic [3:0] bus_out;
  logic bus_oe;

  int total = 0, bad = 0;
  bit done = 1'b0;
  logic [3:0] model [64];

  always #(CLK_P/2) clk = ~clk;

  mwport_ctrl u_mwport_ctrl (
    .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
    .wr_en_n(wr_en_n), .out_en_n(out_en_n), .row_addr(row_addr),
    .col_addr(col_addr), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_write(input logic [2:0] r, input logic [2:0] c,
                          input logic [3:0] m, input logic [3:0] d, input bit col_first);
    row_addr = r; bus_in = m; row_stb_n = 1'b0; tick();
    if (col_first) begin
      col_addr = c; col_stb_n = 1'b0; tick();
      bus_in = d; wr_en_n = 1'b0; tick();
    end else begin
      bus_in = d; wr_en_n = 1'b0; tick();
      col_addr = c; col_stb_n = 1'b0; tick();
    end
    row_stb_n = 1'b1; col_stb_n = 1'b1; wr_en_n = 1'b1; bus_in = 4'h0; tick();
    model[{r, c}] = (model[{r, c}] & ~m) | (d & m);
  endtask

  task automatic do_read(input logic [2:0] r, input logic [2:0] c,
                         output logic [3:0] q, output logic oe);
    row_addr = r; bus_in = 4'h0; row_stb_n = 1'b0; tick();
    col_addr = c; col_stb_n = 1'b0; out_en_n = 1'b0; tick();
    @(negedge clk); q = bus_out; oe = bus_oe;
    row_stb_n = 1'b1; col_stb_n = 1'b1; out_en_n = 1'b1; tick();
  endtask

  task automatic t_reset();
    logic [3:0] q; logic oe;
    @(negedge clk);
    check("R1 oe", {3'b0, bus_oe}, 4'h0);
    do_read(3'd5, 3'd6, q, oe);
    check("R1 word", q, 4'h0);
  endtask

  task automatic t_col_first();
    logic [3:0] q; logic oe;
    do_write(3'd1, 3'd2, 4'hF, 4'hA, 1'b1);
    do_read(3'd1, 3'd2, q, oe);
    check("R5 data", q, model[{3'd1, 3'd2}]);
    check("R7 oe", {3'b0, oe}, 4'h1);
  endtask

  task automatic t_we_first();
    logic [3:0] q; logic oe;
    do_write(3'd3, 3'd4, 4'hF, 4'h6, 1'b0);
    do_read(3'd3, 3'd4, q, oe);
    check("R6 data", q, 4'h6);
    do_read(3'd3, 3'd0, q, oe);
    check("R6 other col", q, 4'h0);
  endtask

  task automatic t_masked();
    logic [3:0] q; logic oe;
    do_write(3'd1, 3'd2, 4'h5, 4'hF, 1'b1);
    do_read(3'd1, 3'd2, q, oe);
    check("R3 mask 0101", q, 4'hF);
    do_write(3'd3, 3'd4, 4'h3, 4'h9, 1'b0);
    do_read(3'd3, 3'd4, q, oe);
    check("R2 R3 mask 0011", q, 4'h5);
  endtask

  task automatic t_zero_mask();
    logic [3:0] q; logic oe;
    do_write(3'd3, 3'd4, 4'h0, 4'hA, 1'b1);
    do_read(3'd3, 3'd4, q, oe);
    check("R4 col-first", q, 4'h5);
    do_write(3'd3, 3'd4, 4'h0, 4'hA, 1'b0);
    do_read(3'd3, 3'd4, q, oe);
    check("R4 we-first", q, 4'h5);
  endtask

  task automatic t_read_cycle();
    logic [3:0] q; logic oe;
    row_addr = 3'd1; bus_in = 4'hF; row_stb_n = 1'b0; tick();
    col_addr = 3'd2; col_stb_n = 1'b0; bus_in = 4'h0; tick(); tick();
    row_stb_n = 1'b1; col_stb_n = 1'b1; tick();
    do_read(3'd1, 3'd2, q, oe);
    check("R11 unchanged", q, 4'hF);
  endtask

  task automatic t_release(input bit col_rises_first);
    row_addr = 3'd3; row_stb_n = 1'b0; tick();
    col_addr = 3'd4; col_stb_n = 1'b0; out_en_n = 1'b1; tick();
    @(negedge clk);
    check("R7 oe high blocks", {3'b0, bus_oe}, 4'h0);
    out_en_n = 1'b0; #1;
    check("R7 drive", {3'b0, bus_oe}, 4'h1);
    check("R7 data", bus_out, 4'h5);
    if (col_rises_first) begin
      col_stb_n = 1'b1; #1;
      check("R8 col release", {3'b0, bus_oe}, 4'h0);
    end else begin
      out_en_n = 1'b1; #1;
      check("R9 oe release", {3'b0, bus_oe}, 4'h0);
    end
    tick(); @(negedge clk);
    check(col_rises_first ? "R8 stays off" : "R9 stays off", {3'b0, bus_oe}, 4'h0);
    row_stb_n = 1'b1; col_stb_n = 1'b1; out_en_n = 1'b1; tick();
  endtask

  task automatic t_discard();
    logic [3:0] q; logic oe;
    do_write(3'd6, 3'd1, 4'hF, 4'hC, 1'b1);
    col_addr = 3'd1; row_addr = 3'd6; bus_in = 4'h3;
    col_stb_n = 1'b0; tick(); wr_en_n = 1'b0; tick(); tick();
    col_stb_n = 1'b1; wr_en_n = 1'b1; tick();
    do_read(3'd6, 3'd1, q, oe);
    check("R10 no row", q, 4'hC);
    do_write(3'd6, 3'd1, 4'h0, 4'h3, 1'b0);
    do_read(3'd6, 3'd1, q, oe);
    check("R10 new mask", q, 4'hC);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 4'h0;
    repeat (3) tick();
    rst_n = 1'b1; tick();
    t_reset();
    t_col_first();
    t_we_first();
    t_masked();
    t_zero_mask();
    t_read_cycle();
    t_release(1'b1);
    t_release(1'b0);
    t_discard();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule